// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave for a two-wire serial bus. It fronts an internal byte array and stores the bytes written to it. A fast system clock oversamples the SCL and SDA lines. SDA is open drain: the block reads the wired line on one input and pulls it low through an output enable. Three strap inputs give the hardware address, so up to eight such slaves can share one bus. A write-protect input blocks every change to the array.

A master opens each transaction with a start condition and then sends a device address. A write carries a two-byte word address and then up to a page of data. The data bytes wait in a page buffer and go into the array when the stop arrives. A self-timed write cycle follows, and the block ignores the bus while it runs. A master can poll for the end of that cycle by sending the device address until the block acknowledges it. Reads come in three kinds: from the current address, from an address loaded by a short write, and as a sequential burst.

The full array is 8,192 bytes (`MEM_AW` = 13). The default of 10 keeps the model small for simulation. Word-address bits above `MEM_AW` are ignored.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0). The block changes its SDA drive only while the synchronised SCL is low. It pulls SDA only in an acknowledge slot or to send a read-data 0 bit.
- R2: The device address byte is sent MSB first. Its bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a mismatch the block returns to idle and leaves SDA released during the ninth clock.
- R3: In a write transaction the block pulls SDA low during the ninth clock after each accepted byte: the device address, both word-address bytes and each data byte.
- R4: The word address is the low 5 bits of the first address byte followed by all 8 bits of the second byte. The top 3 bits of the first byte are ignored, and only the low `MEM_AW` bits select a byte.
- R5: In a page write only the low 5 address bits advance after each data byte. A byte that follows the last byte of a 32-byte page goes to the first byte of the same page.
- R6: When more than 32 data bytes arrive, later bytes overwrite the ones that were buffered earlier at the same page position. The last byte written to each position is the one stored.
- R7: A stop that follows at least one stored data byte starts a write cycle of `WRITE_CYCLES` clocks. During that cycle SDA stays released and no device address is acknowledged. After the cycle the block acknowledges again.
- R8: While `wp_i` is 1, data bytes are still acknowledged. They are discarded, the array is left unchanged and no write cycle starts.
- R9: A read that starts straight after the device address returns the byte at the last accessed address plus one.
- R10: A random read is a write transaction that carries only the two word-address bytes, then a repeated start and a read device address. It returns the byte at the loaded address.
- R11: In a sequential read, each byte the master acknowledges is followed by the byte at the next address. The address rolls from the last byte of the array to 0. The burst ends after a byte the master does not acknowledge.
- R12: A stop that follows only the word-address bytes loads the address counter and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Hardware address straps compared with device address bits 3..1 |
| wp_i | input | 1 | 1 blocks all writes to the array |

## Verification
Writes are tried in several shapes, each read back:
- A two-byte write with junk in the ignored top address bits, which checks address decoding.
- A partial page that crosses the page end, which separates page wrap from a linear increment.
- A 34-byte page, which shows that later bytes win.
- A protected write and an address-only write. These show the difference between a transaction that acknowledges and commits and one that acknowledges and does nothing.

Address bytes with the wrong type code or the wrong strap bits show that the address match needs both fields. A poll straight after a committed write, and a second poll after the write cycle, show that the busy window exists and that it ends. Reads are tried from the current address, from a loaded address and as a burst across the end of the array, which separates page wrap from array wrap.

// File: rtl/ee_pkg.sv
`timescale 1ns/1ps
package ee_pkg;

  // Strobes from the control to the datapath; each is a single-cycle pulse.
  typedef struct packed {
    logic shiftEn;    // shift the sampled SDA bit into the receive register
    logic loadHi;     // latch the high word-address byte
    logic loadLo;     // form the address counter from both address bytes
    logic storeData;  // place a data byte in the page buffer
    logic incRead;    // advance the address counter after a read byte
    logic commit;     // copy the valid page-buffer bytes into the array
    logic clearPage;  // drop all page-buffer valid flags
  } ee_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_BUSY
  } ee_state_t;

endpackage

// File: rtl/ee_bus_sampler.sv
`timescale 1ns/1ps
// Synchronises SCL and SDA and finds clock edges and start/stop conditions.
module ee_bus_sampler #(
  parameter int SYNC_STAGES = 2   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int LANES = 2;

  logic [LANES-1:0] rawIn;
  logic [LANES-1:0] lvl;
  logic [LANES-1:0] prev;

  assign rawIn = {sda_i, scl_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] pipe;
    logic prevQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe  <= '1;
        prevQ <= 1'b1;
      end else begin
        pipe  <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
        prevQ <= pipe[SYNC_STAGES-1];
      end
    end
    assign lvl[g]  = pipe[SYNC_STAGES-1];
    assign prev[g] = prevQ;
  end

  assign sclLvl    = lvl[0];
  assign sdaLvl    = lvl[1];
  assign sclRise   = lvl[0] & ~prev[0];
  assign sclFall   = ~lvl[0] & prev[0];
  assign startSeen = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stopSeen  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/ee_control.sv
`timescale 1ns/1ps
// Bus protocol sequencer: byte framing, acknowledge, read shifting, busy timer.
module ee_control
  import ee_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic [7:0] rxNext,
  input  logic [7:0] txByte,
  input  logic       pageAny,
  input  logic [2:0] strap,
  input  logic       wp,
  output ee_strobe_t strb,
  output logic       sdaOe,
  output logic       busy
);
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  ee_state_t         state;
  logic [3:0]        bitCnt;     // rising edges seen in the current 9-clock frame
  logic              ackGo;
  logic              readMode;
  logic              masterAck;
  logic [BUSY_W-1:0] busyCnt;

  logic rxState;
  logic byteDone;
  logic devHit;

  always_comb begin
    rxState  = state inside {ST_DEV, ST_AHI, ST_ALO, ST_WDAT};
    byteDone = rxState && sclRise && (bitCnt == 4'd7);
    devHit   = (rxNext[7:1] == {TYPE_CODE, strap});
    strb         = '0;
    strb.shiftEn = rxState && sclRise && (bitCnt < 4'd8);
    if (byteDone) begin
      case (state)
        ST_DEV:  strb.clearPage = devHit && !rxNext[0];
        ST_AHI:  strb.loadHi    = 1'b1;
        ST_ALO:  strb.loadLo    = 1'b1;
        ST_WDAT: strb.storeData = !wp;
        default: ;
      endcase
    end
    strb.incRead = (state == ST_RDAT) && sclRise && (bitCnt == 4'd8);
    strb.commit  = stopSeen && (state == ST_WDAT) && pageAny && !wp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackGo     <= 1'b0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
      busyCnt   <= '0;
    end else if (state == ST_BUSY) begin
      sdaOe <= 1'b0;
      if (busyCnt == BUSY_W'(WRITE_CYCLES - 1)) begin
        state   <= ST_IDLE;
        busyCnt <= '0;
      end else begin
        busyCnt <= busyCnt + 1'b1;
      end
    end else if (startSeen) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopSeen) begin
      state   <= strb.commit ? ST_BUSY : ST_IDLE;
      sdaOe   <= 1'b0;
      busyCnt <= '0;
    end else if (rxState) begin
      if (sclRise) begin
        if (bitCnt == 4'd8)     bitCnt <= 4'd9;
        else if (bitCnt < 4'd8) bitCnt <= bitCnt + 1'b1;
        if (byteDone) begin
          ackGo <= (state == ST_DEV) ? devHit : 1'b1;
          if (state == ST_DEV) readMode <= rxNext[0];
        end
      end
      if (sclFall && bitCnt == 4'd8) begin
        sdaOe <= ackGo;
        if (!ackGo) state <= ST_IDLE;
      end
      if (sclFall && bitCnt == 4'd9) begin
        bitCnt <= '0;
        sdaOe  <= 1'b0;
        case (state)
          ST_DEV: begin
            if (readMode) begin
              state <= ST_RDAT;
              sdaOe <= ~txByte[7];
            end else begin
              state <= ST_AHI;
            end
          end
          ST_AHI:  state <= ST_ALO;
          ST_ALO:  state <= ST_WDAT;
          default: ;
        endcase
      end
    end else if (state == ST_RDAT) begin
      if (sclRise) begin
        if (bitCnt == 4'd8) begin
          masterAck <= !sdaLvl;
          bitCnt    <= 4'd9;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (sclFall) begin
        if (bitCnt == 4'd8) begin
          sdaOe <= 1'b0;
        end else if (bitCnt == 4'd9) begin
          bitCnt <= '0;
          if (masterAck) begin
            sdaOe <= ~txByte[7];
          end else begin
            sdaOe <= 1'b0;
            state <= ST_IDLE;
          end
        end else if (bitCnt != 4'd0) begin
          sdaOe <= ~txByte[3'(4'd7 - bitCnt)];
        end
      end
    end
  end

  assign busy = (state == ST_BUSY);
endmodule

// File: rtl/ee_datapath.sv
`timescale 1ns/1ps
// Receive shifter, address counter, page buffer and byte array.
module ee_datapath
  import ee_pkg::*;
#(
  parameter int MEM_AW  = 10,  // 9..13
  parameter int PAGE_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ee_strobe_t        strb,
  input  logic              sdaLvl,
  output logic [7:0]        rxNext,
  output logic [7:0]        txByte,
  output logic              pageAny,
  output logic [MEM_AW-1:0] addrCnt
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int PAGE_N    = 1 << PAGE_AW;
  localparam int HI_W      = MEM_AW - 8;
  localparam int ROW_W     = MEM_AW - PAGE_AW;

  logic [6:0]         rxShift;
  logic [HI_W-1:0]    addrHi;
  logic [PAGE_N-1:0]  pageVld;
  logic [7:0]         pageBuf [PAGE_N];
  logic [7:0]         mem     [MEM_DEPTH];
  logic [ROW_W-1:0]   row;
  logic [PAGE_AW-1:0] col;

  assign row    = addrCnt[MEM_AW-1:PAGE_AW];
  assign col    = addrCnt[PAGE_AW-1:0];
  assign rxNext = {rxShift, sdaLvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      addrHi  <= '0;
      addrCnt <= '0;
      pageVld <= '0;
    end else begin
      if (strb.shiftEn) rxShift <= rxNext[6:0];
      if (strb.loadHi)  addrHi  <= rxNext[HI_W-1:0];
      if (strb.loadLo)         addrCnt <= {addrHi, rxNext};
      else if (strb.storeData) addrCnt <= {row, col + 1'b1};
      else if (strb.incRead)   addrCnt <= addrCnt + 1'b1;
      if (strb.clearPage || strb.commit) pageVld      <= '0;
      else if (strb.storeData)           pageVld[col] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeData) pageBuf[col] <= rxNext;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (pageVld[i]) mem[{row, PAGE_AW'(i)}] <= pageBuf[i];
      end
    end
  end

  assign txByte  = mem[addrCnt];
  assign pageAny = |pageVld;
endmodule

// File: rtl/serial_eeprom_slave.sv
`timescale 1ns/1ps
module serial_eeprom_slave
  import ee_pkg::*;
#(
  parameter int MEM_AW       = 10,
  parameter int PAGE_AW      = 5,
  parameter int WRITE_CYCLES = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  ee_strobe_t        strb;
  logic              sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0]        rxNext, txByte;
  logic              pageAny, busy;
  logic [MEM_AW-1:0] addrCnt;

  ee_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  ee_control #(.WRITE_CYCLES(WRITE_CYCLES)) u_control (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLvl(sdaLvl), .startSeen(startSeen), .stopSeen(stopSeen),
    .rxNext(rxNext), .txByte(txByte), .pageAny(pageAny),
    .strap(strap_i), .wp(wp_i), .strb(strb), .sdaOe(sda_oe), .busy(busy)
  );

  ee_datapath #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_datapath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdaLvl(sdaLvl),
    .rxNext(rxNext), .txByte(txByte), .pageAny(pageAny), .addrCnt(addrCnt)
  );
endmodule

// File: rtl/ee_checker.sv
`timescale 1ns/1ps
module ee_checker #(
  parameter int MEM_AW  = 10,
  parameter int PAGE_AW = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sdaOe,
  input logic                     sclLvl,
  input logic                     busy,
  input logic                     commit,
  input logic                     storeData,
  input logic                     wp,
  input logic                     pageAny,
  input logic [MEM_AW-PAGE_AW-1:0] addrRow
);
  // R1: the SDA drive only moves while SCL is low
  p_drive_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaOe) |-> !sclLvl);

  // R7: SDA stays released during the write cycle
  p_busy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sdaOe);

  // R7: a commit enters the write cycle
  p_commit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R8: with protection on, the page buffer never gains a valid byte
  p_wp_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && !pageAny) |=> !pageAny);

  // R5: storing a page byte never moves the page row
  p_page_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    storeData |=> $stable(addrRow));
endmodule

bind serial_eeprom_slave ee_checker #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_checker (
  .clk(clk), .rst_n(rst_n), .sdaOe(sda_oe), .sclLvl(sclLvl), .busy(busy),
  .commit(strb.commit), .storeData(strb.storeData), .wp(wp_i),
  .pageAny(pageAny), .addrRow(addrCnt[MEM_AW-1:PAGE_AW])
);

// File: tb/test_serial_eeprom_slave.sv
`timescale 1ns/1ps
module test_serial_eeprom_slave;
  localparam int MEM_AW       = 10;
  localparam int WRITE_CYCLES = 1000;
  localparam int Q            = 6;   // system clocks per quarter bus bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       msda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       wp = 1'b0;
  logic       sdaOe;
  logic       sdaBus;

  int checks = 0;
  int errors = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] gotQ[$];
  logic [7:0] wdata [64];
  logic [7:0] monGot, monExp;
  string      monTag;

  always #2.5 clk = ~clk;
  assign sdaBus = msda & ~sdaOe;

  serial_eeprom_slave #(.MEM_AW(MEM_AW), .WRITE_CYCLES(WRITE_CYCLES)) i_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sdaBus), .sda_oe(sdaOe),
    .strap_i(strap), .wp_i(wp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: compares each received byte with the next expectation
  always @(negedge clk) begin
    if (gotQ.size() > 0) begin
      monGot = gotQ.pop_front();
      if (expQ.size() > 0) begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        check(monGot == monExp, monTag, monGot, monExp);
      end else begin
        check(1'b0, "scoreboard unexpected byte", monGot, 0);
      end
    end
  end

  task automatic expectByte(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic busStart();
    msda = 1'b1; tick(Q);
    scl  = 1'b1; tick(Q);
    msda = 1'b0; tick(Q);
    scl  = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    msda = 1'b0; tick(Q);
    scl  = 1'b1; tick(Q);
    msda = 1'b1; tick(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; tick(Q);
      scl  = 1'b1; tick(2*Q);
      scl  = 1'b0; tick(Q);
    end
    msda = 1'b1; tick(Q);
    scl  = 1'b1; tick(Q);
    ack  = (sdaBus == 1'b0);
    tick(Q);
    scl  = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl  = 1'b1; tick(Q);
      b[i] = sdaBus;
      tick(Q);
      scl  = 1'b0; tick(Q);
    end
    msda = mack ? 1'b0 : 1'b1; tick(Q);
    scl  = 1'b1; tick(2*Q);
    scl  = 1'b0; tick(Q);
    msda = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic sendAddr(input int addr, input bit junkHi);
    bit a;
    logic [7:0] hi;
    hi = 8'((addr >> 8) & 32'h1F);
    if (junkHi) hi = hi | 8'hE0;
    sendByte(devByte(1'b0), a); check(a == 1'b1, "R3 device address write ack", a, 1);
    sendByte(hi, a);            check(a == 1'b1, "R3 word address high ack", a, 1);
    sendByte(8'(addr), a);      check(a == 1'b1, "R3 word address low ack", a, 1);
  endtask

  task automatic doWrite(input int addr, input int n, input bit junkHi, input string tag);
    bit a;
    busStart();
    sendAddr(addr, junkHi);
    for (int k = 0; k < n; k++) begin
      sendByte(wdata[k], a);
      check(a == 1'b1, tag, a, 1);
    end
    busStop();
  endtask

  task automatic readCur(input int n);
    bit a;
    logic [7:0] b;
    busStart();
    sendByte(devByte(1'b1), a); check(a == 1'b1, "R3 device address read ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      gotQ.push_back(b);
    end
    busStop();
    tick(2);
  endtask

  task automatic randomRead(input int addr, input int n);
    busStart();
    sendAddr(addr, 1'b0);
    readCur(n);
  endtask

  task automatic poll(output bit a);
    busStart();
    sendByte(devByte(1'b0), a);
    busStop();
  endtask

  task automatic waitBusy();
    tick(WRITE_CYCLES + 200);
  endtask

  initial begin : watchdog
    tick(190000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit a;
    tick(10);
    rst_n = 1'b1;
    tick(10);
    check(sdaOe == 1'b0, "R1 SDA released after reset", sdaOe, 0);
    busStart(); busStop();
    check(sdaOe == 1'b0, "R1 SDA released after empty start/stop", sdaOe, 0);

    // R2: address mismatches
    busStart(); sendByte({4'b1010, 3'b100, 1'b0}, a); busStop();
    check(a == 1'b0, "R2 strap mismatch not acknowledged", a, 0);
    busStart(); sendByte({4'b1011, 3'b101, 1'b0}, a); busStop();
    check(a == 1'b0, "R2 type code mismatch not acknowledged", a, 0);
    busStart(); sendByte({4'b1010, 3'b001, 1'b1}, a); busStop();
    check(a == 1'b0, "R2 read-mode strap mismatch not acknowledged", a, 0);

    // R4 / R7: two-byte write with junk high address bits
    wdata[0] = 8'hA5; wdata[1] = 8'h5A;
    doWrite(32'h0010, 2, 1'b1, "R3 data ack");
    poll(a);
    check(a == 1'b0, "R7 no ack during write cycle", a, 0);
    waitBusy();
    poll(a);
    check(a == 1'b1, "R7 ack after write cycle", a, 1);

    // R10 then R9
    expectByte(8'hA5, "R10 random read 0x010 (R4 junk bits ignored)");
    randomRead(32'h0010, 1);
    expectByte(8'h5A, "R9 current address read 0x011");
    readCur(1);

    // R5: partial page crossing the page end
    for (int k = 0; k < 6; k++) wdata[k] = 8'(8'h31 + k);
    doWrite(32'h003C, 6, 1'b0, "R5 page data ack");
    waitBusy();
    for (int k = 0; k < 4; k++) expectByte(8'(8'h31 + k), "R5 bytes before page end");
    randomRead(32'h003C, 4);
    expectByte(8'h35, "R5 wrapped byte at page start");
    expectByte(8'h36, "R5 wrapped byte at page start+1");
    randomRead(32'h0020, 2);

    // R6: 34 bytes into one page
    for (int k = 0; k < 34; k++) wdata[k] = 8'(8'h80 + k);
    doWrite(32'h0040, 34, 1'b0, "R6 page data ack");
    waitBusy();
    for (int j = 0; j < 32; j++)
      expectByte((j < 2) ? 8'(8'hA0 + j) : 8'(8'h80 + j), "R6 overwritten page readback (R11 burst)");
    randomRead(32'h0040, 32);

    // R8: write protect
    wp = 1'b1;
    wdata[0] = 8'hFF;
    doWrite(32'h0010, 1, 1'b0, "R8 protected data still acknowledged");
    poll(a);
    check(a == 1'b1, "R8 no write cycle when protected", a, 1);
    expectByte(8'hA5, "R8 protected location unchanged");
    randomRead(32'h0010, 1);
    wp = 1'b0;

    // R12: address-only write
    doWrite(32'h003E, 0, 1'b0, "R12 unused");
    poll(a);
    check(a == 1'b1, "R12 no write cycle after address-only stop", a, 1);
    expectByte(8'h33, "R12 counter loaded by address-only write");
    readCur(1);

    // R11: sequential read rolls over the end of the array
    wdata[0] = 8'h11;
    doWrite(32'h03FF, 1, 1'b0, "R3 data ack");
    waitBusy();
    wdata[0] = 8'h22;
    doWrite(32'h0000, 1, 1'b0, "R3 data ack");
    waitBusy();
    expectByte(8'h11, "R11 last array byte");
    expectByte(8'h22, "R11 rolled to address 0");
    randomRead(32'h03FF, 2);

    tick(20);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule